// File: doc/BRIEF.md
# Interrupt Acknowledge and Cascade Sequencer

This block answers a processor's three-pulse interrupt-acknowledge handshake. The first acknowledge pulse places a subroutine-call opcode on the data bus. The second pulse places the low byte of the service-routine address, and the third places the high byte. The address is the programmed base plus the winning request level times a fixed spacing of four bytes. The winning level comes from an external priority resolver and is captured on the first pulse.

The block can be wired into a two-tier cascade. A master drives the winning level on a 3-bit cascade bus whenever that input has a slave behind it. In that case the master supplies only the opcode. A slave compares the cascade code with its own identifier and drives the two address bytes only on a match.

The role (master or slave) is read from the role pin in non-buffered mode. In buffered mode it comes from a configuration bit, and the pin's function becomes a bus-buffer enable output. Automatic end-of-interrupt produces a one-cycle request after the last pulse ends, in master role only. Special nested mode tells the priority logic which in-service inputs may request again.

Top module: `intack_seq`

## Requirements
- R1: After reset, driveEn, bufEnOut, casOe and eoiReq are all 0.
- R2: The pulses of each sequence drive, in order: first the opcode 0xCD, then address bits [7:0], then address bits [15:8]. After the third pulse, the next pulse starts a new sequence with the opcode again.
- R3: The address is vecBase + 4*level, modulo 2^16. The level is the one presented with reqValid=1 on the first pulse, and later changes to reqLevel or reqValid have no effect within the sequence.
- R4: If reqValid is 0 on the first pulse, the sequence delivers the level-7 address.
- R5: In master role with modeAeoi=1, eoiReq is high for exactly one cycle: the cycle after the end of the third pulse is sampled. In every other case eoiReq stays 0.
- R6: In slave role, eoiReq stays 0 even when modeAeoi=1.
- R7: Suppose the block is master and the captured level has its bit set in slaveMap (bit i means input i has a slave). Then casOe=1 and casOut=level from the first pulse until the third pulse ends, and driveEn stays 0 on pulses two and three. Otherwise casOe=0 and casOut=0.
- R8: In slave role, driveEn stays 0 on the first pulse. On pulses two and three it is 1 exactly when casIn equals slaveId.
- R9: With modeBuffered=1, the role is master when modeBufMaster=1, msPinIn is ignored, and bufEnOut equals driveEn. With modeBuffered=0, the role is master when msPinIn=1, and bufEnOut stays 0.
- R10: nestAllow equals slaveMap when the role is master and modeSpecNest=1, and is 0 otherwise.
- R11: driveEn rises in the cycle after the start of a pulse is sampled. It falls in the cycle after the end of that pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ackIn | input | 1 | Acknowledge strobe, high during a pulse |
| reqLevel | input | 3 | Winning level from the priority resolver |
| reqValid | input | 1 | A request is pending |
| vecBase | input | 16 | Programmed service-routine base address |
| modeBuffered | input | 1 | Buffered-bus mode |
| modeBufMaster | input | 1 | Role in buffered mode (1 = master) |
| modeAeoi | input | 1 | Automatic end-of-interrupt enable |
| modeSpecNest | input | 1 | Special nested mode |
| slaveMap | input | 8 | Inputs that have a slave attached |
| slaveId | input | 3 | This block's identifier when it is a slave |
| msPinIn | input | 1 | Role pin read in non-buffered mode (1 = master) |
| casIn | input | 3 | Cascade code received from a master |
| dataOut | output | 8 | Byte for the data bus |
| driveEn | output | 1 | Data-bus drive enable |
| bufEnOut | output | 1 | System bus-buffer enable, buffered mode only |
| casOut | output | 3 | Cascade code driven as master |
| casOe | output | 1 | Cascade bus drive enable |
| eoiReq | output | 1 | One-cycle non-specific end-of-interrupt request |
| nestAllow | output | 8 | In-service inputs allowed to request again |

## Verification
The assertions assume three things about the inputs. First, the mode inputs, the role pin and slaveMap hold still from the first pulse of a sequence until its end-of-interrupt cycle has passed. Second, every pulse lasts at least one sampled cycle. Third, pulses are separated by at least one low cycle. The stimulus changes configuration only between sequences, after the cycle that follows the third trailing edge. It drives every pulse as one high sample followed by idle samples. The stimulus deliberately changes reqLevel and reqValid between pulses, because these two inputs are only required to be valid at the first pulse.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [1:0] {PULSE_CALL = 2'd0, PULSE_LO = 2'd1, PULSE_HI = 2'd2} pulse_e;

  typedef struct packed {
    logic   rise;
    logic   fall;
    logic   seqEnd;
    pulse_e sel;
  } ackStrobes_t;
endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackIn,
  output ackStrobes_t stb
);
  logic   ackPrev;
  logic   lastPulse;
  pulse_e pulseCnt;
  logic   riseNow;
  logic   fallNow;

  assign riseNow = ackIn & ~ackPrev;
  assign fallNow = ~ackIn & ackPrev;

  always_comb begin
    stb.rise   = riseNow;
    stb.fall   = fallNow;
    stb.seqEnd = fallNow & lastPulse;
    stb.sel    = pulseCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev   <= 1'b0;
      lastPulse <= 1'b0;
      pulseCnt  <= PULSE_CALL;
    end else begin
      ackPrev <= ackIn;
      if (riseNow) begin
        lastPulse <= (pulseCnt == PULSE_HI);
        pulseCnt  <= (pulseCnt == PULSE_HI) ? PULSE_CALL : pulse_e'(pulseCnt + 2'd1);
      end else if (fallNow) begin
        lastPulse <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/intack_dp.sv
module intack_dp
  import intack_pkg::*;
#(
  parameter int LEVELS  = 8,
  parameter int DATA_W  = 8,
  parameter int SPACING = 4,
  parameter logic [7:0] CALL_OP = 8'hCD,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ackStrobes_t       stb,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic              isMaster,
  input  logic              modeAeoi,
  input  logic [LEVELS-1:0] slaveMap,
  input  logic [LVL_W-1:0]  slaveId,
  input  logic [LVL_W-1:0]  casIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn,
  output logic [LVL_W-1:0]  casOut,
  output logic              casOe,
  output logic              eoiReq
);
  logic [LVL_W-1:0]  lvlHeld;
  logic              cascHeld;
  logic [LVL_W-1:0]  pickLevel;
  logic              newCasc;
  logic [ADDR_W-1:0] vecAddr;

  assign pickLevel = reqValid ? reqLevel : LVL_W'(LEVELS - 1);
  assign newCasc   = isMaster & reqValid & slaveMap[reqLevel];
  assign vecAddr   = vecBase + ADDR_W'(lvlHeld) * ADDR_W'(SPACING);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlHeld  <= '0;
      cascHeld <= 1'b0;
      dataOut  <= '0;
      driveEn  <= 1'b0;
      casOut   <= '0;
      casOe    <= 1'b0;
      eoiReq   <= 1'b0;
    end else begin
      eoiReq <= 1'b0;
      if (stb.rise) begin
        if (stb.sel == PULSE_CALL) begin
          lvlHeld  <= pickLevel;
          cascHeld <= newCasc;
          casOut   <= newCasc ? reqLevel : '0;
          casOe    <= newCasc;
          dataOut  <= DATA_W'(CALL_OP);
          driveEn  <= isMaster;
        end else begin
          dataOut <= (stb.sel == PULSE_LO) ? vecAddr[DATA_W-1:0] : vecAddr[ADDR_W-1:DATA_W];
          driveEn <= isMaster ? ~cascHeld : (casIn == slaveId);
        end
      end else if (stb.fall) begin
        driveEn <= 1'b0;
        dataOut <= '0;
        if (stb.seqEnd) begin
          casOe    <= 1'b0;
          casOut   <= '0;
          cascHeld <= 1'b0;
          eoiReq   <= isMaster & modeAeoi;
        end
      end
    end
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int LEVELS  = 8,
  parameter int DATA_W  = 8,
  parameter int SPACING = 4,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackIn,
  input  logic [LVL_W-1:0]  reqLevel,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] vecBase,
  input  logic              modeBuffered,
  input  logic              modeBufMaster,
  input  logic              modeAeoi,
  input  logic              modeSpecNest,
  input  logic [LEVELS-1:0] slaveMap,
  input  logic [LVL_W-1:0]  slaveId,
  input  logic              msPinIn,
  input  logic [LVL_W-1:0]  casIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn,
  output logic              bufEnOut,
  output logic [LVL_W-1:0]  casOut,
  output logic              casOe,
  output logic              eoiReq,
  output logic [LEVELS-1:0] nestAllow
);
  ackStrobes_t stb;
  logic        isMaster;

  assign isMaster  = modeBuffered ? modeBufMaster : msPinIn;
  assign bufEnOut  = modeBuffered & driveEn;
  assign nestAllow = (isMaster & modeSpecNest) ? slaveMap : '0;

  intack_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ackIn (ackIn),
    .stb   (stb)
  );

  intack_dp #(
    .LEVELS  (LEVELS),
    .DATA_W  (DATA_W),
    .SPACING (SPACING)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqLevel (reqLevel),
    .reqValid (reqValid),
    .vecBase  (vecBase),
    .isMaster (isMaster),
    .modeAeoi (modeAeoi),
    .slaveMap (slaveMap),
    .slaveId  (slaveId),
    .casIn    (casIn),
    .dataOut  (dataOut),
    .driveEn  (driveEn),
    .casOut   (casOut),
    .casOe    (casOe),
    .eoiReq   (eoiReq)
  );
endmodule

// File: rtl/intack_chk.sv
module intack_chk #(
  parameter int LEVELS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ackIn,
  input logic              driveEn,
  input logic              bufEnOut,
  input logic              modeBuffered,
  input logic              modeBufMaster,
  input logic              msPinIn,
  input logic              eoiReq,
  input logic              casOe,
  input logic [LEVELS-1:0] slaveMap,
  input logic [LEVELS-1:0] nestAllow
);
  AST_EOI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    eoiReq |=> !eoiReq); // R5
  AST_EOI_AFTER_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    eoiReq |-> $past(!ackIn)); // R5
  AST_EOI_NOT_SLAVE: assert property (@(posedge clk) disable iff (!rstN)
    eoiReq |-> (modeBuffered ? modeBufMaster : msPinIn)); // R6
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> $past(ackIn)); // R11
  AST_BUFEN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    bufEnOut |-> (driveEn && modeBuffered)); // R9
  AST_CAS_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    casOe |-> (modeBuffered ? modeBufMaster : msPinIn)); // R7
  AST_NEST_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (nestAllow & ~slaveMap) == '0); // R10
endmodule

bind intack_seq intack_chk #(.LEVELS(LEVELS)) i_chk (.*);

// File: tb/test_intack_seq.sv
module test_intack_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ackIn = 1'b0;
  logic [2:0]  reqLevel = '0;
  logic        reqValid = 1'b0;
  logic [15:0] vecBase = '0;
  logic        modeBuffered = 1'b0;
  logic        modeBufMaster = 1'b0;
  logic        modeAeoi = 1'b0;
  logic        modeSpecNest = 1'b0;
  logic [7:0]  slaveMap = '0;
  logic [2:0]  slaveId = '0;
  logic        msPinIn = 1'b1;
  logic [2:0]  casIn = '0;
  logic [7:0]  dataOut;
  logic        driveEn;
  logic        bufEnOut;
  logic [2:0]  casOut;
  logic        casOe;
  logic        eoiReq;
  logic [7:0]  nestAllow;

  int totalCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  intack_seq i_intack_seq (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doSeq(input logic [2:0] lvl, input logic valid);
    logic        master;
    logic [2:0]  effLvl;
    logic [15:0] addr;
    logic        casc;
    logic        expDrive;
    logic [7:0]  expByte;
    master = modeBuffered ? modeBufMaster : msPinIn;
    effLvl = valid ? lvl : 3'd7;
    addr   = vecBase + 16'(effLvl) * 16'd4;
    casc   = master & valid & slaveMap[lvl];
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      if (p == 0) begin
        reqLevel = lvl;
        reqValid = valid;
      end
      ackIn = 1'b1;
      @(negedge clk);
      if (p == 0) begin
        reqLevel = 3'($urandom);
        reqValid = 1'($urandom);
      end
      if (p == 0) begin
        expDrive = master;
        expByte  = 8'hCD;
      end else begin
        expDrive = master ? ~casc : (casIn == slaveId);
        expByte  = (p == 1) ? addr[7:0] : addr[15:8];
      end
      chk("R8_R11 driveEn in pulse", 16'(driveEn), 16'(expDrive));
      if (expDrive) chk(valid ? "R2_R3 data byte" : "R4 data byte", 16'(dataOut), 16'(expByte));
      chk("R9 bufEnOut", 16'(bufEnOut), 16'(modeBuffered & expDrive));
      chk("R7 casOe", 16'(casOe), 16'(casc));
      chk("R7 casOut", 16'(casOut), casc ? 16'(lvl) : 16'd0);
      chk("R5 eoiReq low in pulse", 16'(eoiReq), 16'd0);
      chk("R10 nestAllow", 16'(nestAllow), (master & modeSpecNest) ? 16'(slaveMap) : 16'd0);
      ackIn = 1'b0;
      @(negedge clk);
      chk("R11 driveEn after trail", 16'(driveEn), 16'd0);
      chk("R5_R6 eoiReq after trail", 16'(eoiReq), 16'((p == 2) & master & modeAeoi));
      chk("R7 casOe after trail", 16'(casOe), (p == 2) ? 16'd0 : 16'(casc));
    end
    @(negedge clk);
    chk("R5 eoiReq single cycle", 16'(eoiReq), 16'd0);
  endtask

  initial begin
    #1_500_000;
    failCnt++;
    totalCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    logic [15:0] bases [3];
    bases[0] = 16'h0000;
    bases[1] = 16'h12F8;
    bases[2] = 16'hFFF0;
    #12;
    chk("R1 driveEn", 16'(driveEn), 16'd0);
    chk("R1 casOe", 16'(casOe), 16'd0);
    chk("R1 eoiReq", 16'(eoiReq), 16'd0);
    chk("R1 bufEnOut", 16'(bufEnOut), 16'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 R3 R5: master, no cascade, every level, both end-of-interrupt modes
    msPinIn = 1'b1;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 3; b++)
        for (int l = 0; l < 8; l++) begin
          modeAeoi = 1'(a);
          vecBase  = bases[b];
          doSeq(3'(l), 1'b1);
        end

    // R4: no request pending
    vecBase = 16'h4000;
    for (int l = 0; l < 8; l += 3) doSeq(3'(l), 1'b0);

    // R7 R10: master with slaves on some inputs
    slaveMap = 8'hA5;
    vecBase  = 16'h2200;
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 8; l++) begin
        modeSpecNest = 1'(s);
        doSeq(3'(l), 1'b1);
      end

    // R6 R8: slave role, every identifier against every cascade code
    msPinIn  = 1'b0;
    modeAeoi = 1'b1;
    for (int id = 0; id < 8; id++)
      for (int c = 0; c < 8; c++) begin
        slaveId = 3'(id);
        casIn   = 3'(c);
        doSeq(3'((id + c) % 8), 1'b1);
      end

    // R9: buffered mode, role from config bit, pin ignored
    modeBuffered = 1'b1;
    for (int m = 0; m < 2; m++) begin
      modeBufMaster = 1'(m);
      msPinIn       = ~1'(m);
      slaveId       = 3'd2;
      casIn         = 3'd2;
      for (int l = 0; l < 8; l++) doSeq(3'(l), 1'b1);
    end

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule